// File: doc/BRIEF.md
# Transmit Input Mode Detector

This block sits at the digital transmit input of one channel of a T1/E1 line interface. It watches three asynchronous pins: the transmit clock, the positive-rail data and the negative-rail data. From how those pins behave over time it works out the operating mode. There is no configuration register for the mode.

All detection runs on a free-running master clock. Each pin first passes through a two-flop synchronizer. Saturating run-length counters then measure how long a level persists:

- **Clock held low:** the line driver is switched off.
- **Clock stuck high:** the block requests an all-ones signal when the master reference is reported good. When the reference is not good, it flags pulse shaping as bypassed, and the raw rail levels are passed straight through so that the output pulse widths follow the data duty cycle.
- **Negative rail held high:** when the negative rail stays high across more than the limit of consecutive transmit-clock falling edges, the block moves to single-rail (unipolar) input.

In normal clocked operation the block captures both rails on each falling edge of the transmit clock. It emits either a decoded bipolar symbol, or a single-rail data bit together with the line-code choice. Line coding, pulse shaping and the analog drivers are handled downstream.

Top module: `txin_mode_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0 and `sym_o` is 2'b00 (space).
- R2: Each transmit-clock falling edge, seen after synchronization, raises `sym_vld_o` for exactly one master-clock cycle, three master-clock edges after the pin falls. The rail levels present at that edge are captured and held until the next falling edge.
- R3: In bipolar mode `sym_o` decodes the captured rails {pos,neg} as follows:
  - 00 gives 2'b00 (space)
  - 10 gives 2'b01 (positive mark)
  - 01 gives 2'b10 (negative mark)
  - 11 gives 2'b00 (space)
  - The value 2'b11 never appears.
- R4: `drv_en_o` is 0 from reset until the first transmit-clock falling edge. It is 0 while `clk_low_o` is set. `clk_low_o` sets once the synchronized clock has been low for more than 16 master cycles, and clears on the first high level.
- R5: `clk_high_o` sets once the synchronized clock has been high for more than 16 master cycles, and clears on the first low level. While it is set, `all_ones_o` is 1 when `ref_ok_i` is 1.
- R6: While `clk_high_o` is set and `ref_ok_i` is 0:
  - `shaping_off_o` is 1.
  - `raw_p_o` follows the synchronized pos level when neg is low.
  - `raw_n_o` follows the synchronized neg level when pos is low.
  - Both raw outputs are 0 when both rails are high.
- R7: `unipolar_o` sets on the falling edge that is the 17th consecutive one with the neg rail high. It clears on the first falling edge with the neg rail low. While it is set, `sym_o` is space and `uni_data_o` carries the captured pos bit.
- R8: `subst_code_o` equals `code_sel_i` (1 selects substitution coding, 0 plain AMI) while `unipolar_o` is 1, and is 0 otherwise.
- R9: A run of exactly 16 (clock high for 16 master cycles, or neg high for 16 falling edges) sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_ok_i | input | 1 | Master reference is within stability limits |
| tclk_i | input | 1 | Transmit clock pin (asynchronous) |
| pdat_i | input | 1 | Positive rail / single-rail data pin |
| ndat_i | input | 1 | Negative rail / single-rail select pin |
| code_sel_i | input | 1 | Line-code choice for single-rail mode |
| drv_en_o | output | 1 | Line driver enable |
| clk_low_o | output | 1 | Transmit clock held low |
| clk_high_o | output | 1 | Transmit clock stuck high |
| all_ones_o | output | 1 | Request to send all ones |
| shaping_off_o | output | 1 | Pulse shaping bypassed |
| raw_p_o | output | 1 | Raw positive pulse in bypass |
| raw_n_o | output | 1 | Raw negative pulse in bypass |
| unipolar_o | output | 1 | Single-rail input mode active |
| sym_vld_o | output | 1 | New symbol captured this cycle |
| sym_o | output | 2 | Decoded bipolar symbol |
| uni_data_o | output | 1 | Single-rail data bit |
| subst_code_o | output | 1 | Substitution line code selected |

## Verification
Two functions share one clock edge when the 17th consecutive falling edge with the negative rail high arrives. That edge both captures a new symbol and switches the block to single-rail mode, so the emitted symbol must already read as space in that same cycle. The bench provokes this by sending exactly 16 such bits, checking that no flag has appeared, and then sending one more. A behavioural model compares `sym_o`, `sym_vld_o` and `unipolar_o` on every master-clock cycle, and a checker asserts that the mode flag only rises together with a symbol strobe.

// File: rtl/txin_pkg.sv
package txin_pkg;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_PMARK = 2'b01,
        SYM_NMARK = 2'b10
    } sym_e;

    localparam int unsigned PIN_CNT = 3;
    localparam int unsigned PIN_CLK = 2;
    localparam int unsigned PIN_POS = 1;
    localparam int unsigned PIN_NEG = 0;

    localparam int unsigned DET_CNT   = 3;
    localparam int unsigned DET_CHIGH = 0;
    localparam int unsigned DET_CLOW  = 1;
    localparam int unsigned DET_NRUN  = 2;

endpackage

// File: rtl/txin_sync.sv
module txin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/txin_run_det.sv
module txin_run_det #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    input  logic lvl_i,
    output logic flag_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } run_t;

    run_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (step_i) begin
            if (lvl_i) begin
                if (r_q.cnt == CMAX) r_d.flag = 1'b1;
                else                 r_d.cnt  = r_q.cnt + 1'b1;
            end else begin
                r_d.cnt  = '0;
                r_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign flag_o = r_q.flag;

endmodule

// File: rtl/txin_sym_dec.sv
module txin_sym_dec
    import txin_pkg::*;
(
    input  logic       pos_i,
    input  logic       neg_i,
    input  logic       uni_i,
    output logic [1:0] sym_o
);

    sym_e sym;

    always_comb begin
        sym = SYM_SPACE;
        if (!uni_i) begin
            unique case ({pos_i, neg_i})
                2'b10:   sym = SYM_PMARK;
                2'b01:   sym = SYM_NMARK;
                default: sym = SYM_SPACE;
            endcase
        end
    end

    assign sym_o = sym;

endmodule

// File: rtl/txin_mode_det.sv
module txin_mode_det
    import txin_pkg::*;
#(
    parameter int unsigned STALL_LIMIT = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       mclk_i,
    input  logic       rst_ni,
    input  logic       ref_ok_i,
    input  logic       tclk_i,
    input  logic       pdat_i,
    input  logic       ndat_i,
    input  logic       code_sel_i,
    output logic       drv_en_o,
    output logic       clk_low_o,
    output logic       clk_high_o,
    output logic       all_ones_o,
    output logic       shaping_off_o,
    output logic       raw_p_o,
    output logic       raw_n_o,
    output logic       unipolar_o,
    output logic       sym_vld_o,
    output logic [1:0] sym_o,
    output logic       uni_data_o,
    output logic       subst_code_o
);

    typedef struct packed {
        logic clk_prev;
        logic seen_fall;
        logic pos_smp;
        logic neg_smp;
        logic sym_vld;
    } st_t;

    logic [PIN_CNT-1:0] pin_raw, pin_lvl;
    logic               clk_lvl, pos_lvl, neg_lvl, fall;
    logic [DET_CNT-1:0] det_step, det_lvl, det_flag;
    st_t                st_d, st_q;

    assign pin_raw[PIN_CLK] = tclk_i;
    assign pin_raw[PIN_POS] = pdat_i;
    assign pin_raw[PIN_NEG] = ndat_i;

    txin_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_raw),
        .sync_o  (pin_lvl)
    );

    assign clk_lvl = pin_lvl[PIN_CLK];
    assign pos_lvl = pin_lvl[PIN_POS];
    assign neg_lvl = pin_lvl[PIN_NEG];
    assign fall    = st_q.clk_prev & ~clk_lvl;

    always_comb begin
        det_step = '1;
        det_lvl  = '0;
        det_step[DET_NRUN] = fall;
        det_lvl[DET_CHIGH] = clk_lvl;
        det_lvl[DET_CLOW]  = ~clk_lvl;
        det_lvl[DET_NRUN]  = neg_lvl;
    end

    for (genvar d = 0; d < DET_CNT; d++) begin : g_det
        txin_run_det #(
            .LIMIT (STALL_LIMIT)
        ) u_run (
            .clk_i  (mclk_i),
            .rst_ni (rst_ni),
            .step_i (det_step[d]),
            .lvl_i  (det_lvl[d]),
            .flag_o (det_flag[d])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = clk_lvl;
        st_d.sym_vld  = fall;
        if (fall) begin
            st_d.seen_fall = 1'b1;
            st_d.pos_smp   = pos_lvl;
            st_d.neg_smp   = neg_lvl;
        end
    end

    always_ff @(posedge mclk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    txin_sym_dec u_dec (
        .pos_i (st_q.pos_smp),
        .neg_i (st_q.neg_smp),
        .uni_i (det_flag[DET_NRUN]),
        .sym_o (sym_o)
    );

    assign clk_low_o     = det_flag[DET_CLOW];
    assign clk_high_o    = det_flag[DET_CHIGH];
    assign unipolar_o    = det_flag[DET_NRUN];
    assign drv_en_o      = st_q.seen_fall & ~clk_low_o;
    assign all_ones_o    = clk_high_o & ref_ok_i;
    assign shaping_off_o = clk_high_o & ~ref_ok_i;
    assign raw_p_o       = shaping_off_o & pos_lvl & ~neg_lvl;
    assign raw_n_o       = shaping_off_o & neg_lvl & ~pos_lvl;
    assign sym_vld_o     = st_q.sym_vld;
    assign uni_data_o    = unipolar_o & st_q.pos_smp;
    assign subst_code_o  = unipolar_o & code_sel_i;

endmodule

// File: rtl/txin_mode_det_chk.sv
module txin_mode_det_chk (
    input logic       mclk_i,
    input logic       rst_ni,
    input logic       ref_ok_i,
    input logic       tclk_i,
    input logic       pdat_i,
    input logic       ndat_i,
    input logic       code_sel_i,
    input logic       drv_en_o,
    input logic       clk_low_o,
    input logic       clk_high_o,
    input logic       all_ones_o,
    input logic       shaping_off_o,
    input logic       raw_p_o,
    input logic       raw_n_o,
    input logic       unipolar_o,
    input logic       sym_vld_o,
    input logic [1:0] sym_o,
    input logic       uni_data_o,
    input logic       subst_code_o
);

    // R2
    strobe_single_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        sym_vld_o |=> !sym_vld_o);

    // R3
    sym_legal_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        sym_o != 2'b11);

    // R5
    clk_flags_excl_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        clk_high_o |-> !clk_low_o);

    // R6
    raw_excl_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !(raw_p_o && raw_n_o));

    // R7
    uni_on_edge_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $rose(unipolar_o) |-> sym_vld_o);

    // R7
    uni_space_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        unipolar_o |-> sym_o == 2'b00);

    // R8
    subst_gate_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !unipolar_o |-> !subst_code_o);

endmodule

bind txin_mode_det txin_mode_det_chk u_chk (.*);

// File: tb/tb_txin_mode_det.sv
module tb_txin_mode_det;

    localparam int THR = 16;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_ok = 1'b1, tclk = 1'b0, pdat = 1'b0, ndat = 1'b0, code_sel = 1'b0;
    logic       drv_en, clk_low, clk_high, all_ones, shoff, raw_p, raw_n;
    logic       uni, vld, uni_data, subst;
    logic [1:0] sym;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 mclk = ~mclk;

    txin_mode_det dut (
        .mclk_i(mclk), .rst_ni(rst_n), .ref_ok_i(ref_ok), .tclk_i(tclk),
        .pdat_i(pdat), .ndat_i(ndat), .code_sel_i(code_sel),
        .drv_en_o(drv_en), .clk_low_o(clk_low), .clk_high_o(clk_high),
        .all_ones_o(all_ones), .shaping_off_o(shoff), .raw_p_o(raw_p),
        .raw_n_o(raw_n), .unipolar_o(uni), .sym_vld_o(vld), .sym_o(sym),
        .uni_data_o(uni_data), .subst_code_o(subst)
    );

    // behavioural reference model
    int m_c1, m_c2, m_p1, m_p2, m_n1, m_n2, m_prev;
    int m_hi, m_lo, m_nc, m_shi, m_slo, m_uni, m_seen, m_ps, m_ns, m_vld;

    always @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_p1 = 0; m_p2 = 0; m_n1 = 0; m_n2 = 0; m_prev = 0;
            m_hi = 0; m_lo = 0; m_nc = 0; m_shi = 0; m_slo = 0; m_uni = 0;
            m_seen = 0; m_ps = 0; m_ns = 0; m_vld = 0;
        end else begin
            int f;
            f = (m_prev == 1 && m_c2 == 0) ? 1 : 0;
            if (m_c2 == 1) begin
                if (m_hi == THR) m_shi = 1; else m_hi++;
                m_lo = 0; m_slo = 0;
            end else begin
                if (m_lo == THR) m_slo = 1; else m_lo++;
                m_hi = 0; m_shi = 0;
            end
            if (f == 1) begin
                if (m_n2 == 1) begin
                    if (m_nc == THR) m_uni = 1; else m_nc++;
                end else begin
                    m_nc = 0; m_uni = 0;
                end
                m_ps = m_p2; m_ns = m_n2; m_seen = 1;
            end
            m_vld = f;
            m_prev = m_c2;
            m_c2 = m_c1; m_c1 = int'(tclk);
            m_p2 = m_p1; m_p1 = int'(pdat);
            m_n2 = m_n1; m_n1 = int'(ndat);
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge mclk) begin
        if (rst_n && !done) begin
            int e_shoff, e_sym;
            e_shoff = (m_shi == 1 && !ref_ok) ? 1 : 0;
            if (m_uni == 1)                  e_sym = 0;
            else if (m_ps == 1 && m_ns == 0) e_sym = 1;
            else if (m_ps == 0 && m_ns == 1) e_sym = 2;
            else                             e_sym = 0;
            chk("R4", "drv_en", int'(drv_en), (m_seen == 1 && m_slo == 0) ? 1 : 0);
            chk("R4", "clk_low", int'(clk_low), m_slo);
            chk("R5", "clk_high", int'(clk_high), m_shi);
            chk("R5", "all_ones", int'(all_ones), (m_shi == 1 && ref_ok) ? 1 : 0);
            chk("R6", "shaping_off", int'(shoff), e_shoff);
            chk("R6", "raw_p", int'(raw_p), (e_shoff == 1 && m_p2 == 1 && m_n2 == 0) ? 1 : 0);
            chk("R6", "raw_n", int'(raw_n), (e_shoff == 1 && m_n2 == 1 && m_p2 == 0) ? 1 : 0);
            chk("R7", "unipolar", int'(uni), m_uni);
            chk("R2", "sym_vld", int'(vld), m_vld);
            chk("R3", "sym", int'(sym), e_sym);
            chk("R7", "uni_data", int'(uni_data), (m_uni == 1 && m_ps == 1) ? 1 : 0);
            chk("R8", "subst", int'(subst), (m_uni == 1 && code_sel) ? 1 : 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge mclk);
            #1;
        end
    endtask

    task automatic send_bit(input logic p, input logic n);
        tclk = 1'b1; pdat = p; ndat = n;
        step(4);
        tclk = 1'b0;
        step(4);
    endtask

    bit saw_high;
    always @(negedge mclk) if (clk_high) saw_high = 1;

    initial begin
        step(3);
        // R1: outputs during reset
        chk("R1", "drv_en rst", int'(drv_en), 0);
        chk("R1", "sym rst", int'(sym), 0);
        chk("R1", "unipolar rst", int'(uni), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "drv_en after rst", int'(drv_en), 0);
        chk("R1", "vld after rst", int'(vld), 0);

        // R2/R3: bipolar stream over all rail combinations
        for (int k = 0; k < 24; k++) begin
            send_bit(k[0], k[1]);
            if (k == 0) chk("R4", "drv_en after first fall", int'(drv_en), 1);
        end
        send_bit(1'b1, 1'b0);
        chk("R3", "positive mark held", int'(sym), 1);
        send_bit(1'b0, 1'b1);
        chk("R3", "negative mark held", int'(sym), 2);
        send_bit(1'b1, 1'b1);
        chk("R3", "both high is space", int'(sym), 0);

        // R4: clock held low
        tclk = 1'b0;
        step(30);
        chk("R4", "clk_low set", int'(clk_low), 1);
        chk("R4", "driver off", int'(drv_en), 0);
        send_bit(1'b0, 1'b0);
        chk("R4", "driver back", int'(drv_en), 1);

        // R9: exactly 16 high cycles
        saw_high = 0;
        tclk = 1'b1;
        step(16);
        tclk = 1'b0;
        step(6);
        chk("R9", "no stall at 16", int'(saw_high), 0);

        // R5: stuck high with reference good
        ref_ok = 1'b1;
        tclk = 1'b1;
        step(30);
        chk("R5", "clk_high set", int'(clk_high), 1);
        chk("R5", "all_ones", int'(all_ones), 1);

        // R6: reference lost, raw passthrough
        ref_ok = 1'b0;
        pdat = 1'b1; ndat = 1'b0;
        step(4);
        chk("R6", "shaping_off", int'(shoff), 1);
        chk("R6", "raw_p follows", int'(raw_p), 1);
        pdat = 1'b0; ndat = 1'b1;
        step(4);
        chk("R6", "raw_n follows", int'(raw_n), 1);
        pdat = 1'b1; ndat = 1'b1;
        step(4);
        chk("R6", "both high raw_p", int'(raw_p), 0);
        chk("R6", "both high raw_n", int'(raw_n), 0);
        ref_ok = 1'b1;
        tclk = 1'b0;
        step(4);
        chk("R5", "clk_high clears", int'(clk_high), 0);

        // R9/R7: neg rail runs
        send_bit(1'b0, 1'b0);
        for (int k = 0; k < THR; k++) send_bit(k[0], 1'b1);
        chk("R9", "no unipolar at 16", int'(uni), 0);
        send_bit(1'b1, 1'b1);
        chk("R7", "unipolar set", int'(uni), 1);
        chk("R7", "sym space in unipolar", int'(sym), 0);
        chk("R7", "uni data", int'(uni_data), 1);
        code_sel = 1'b1;
        send_bit(1'b0, 1'b1);
        chk("R7", "uni data zero", int'(uni_data), 0);
        chk("R8", "substitution code", int'(subst), 1);
        code_sel = 1'b0;
        send_bit(1'b1, 1'b1);
        chk("R8", "ami code", int'(subst), 0);
        code_sel = 1'b1;
        send_bit(1'b1, 1'b0);
        chk("R7", "unipolar clears", int'(uni), 0);
        chk("R8", "subst gated off", int'(subst), 0);
        chk("R3", "bipolar again", int'(sym), 1);

        step(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule